// File: doc/BRIEF.md
# Floppy Controller Command Sequencer

This block is the host-facing protocol engine of a floppy disk controller. The host sees three byte registers: a status byte it polls, a data port through which it sends an opcode and parameter bytes and reads result bytes back, and a write-only control byte that drives the motor enables and the selected drive. The sequencer decodes each opcode and collects the number of parameter bytes that command needs. Commands that need media access are passed to an external transfer engine through a start/done handshake. The sequencer then returns the result bytes in a fixed order and goes back to idle.

Seek, recalibrate, specify and the two sense commands finish inside the block. Seek and recalibrate update the present-cylinder register at once. Read, write and format wait in an execution phase until the engine reports completion with an interrupt code and two status bytes. The four status bytes reported to the host are assembled here.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset the status byte (address 4) reads 0x80, the motor enables and drive select are zero, and a data port (address 5) read returns 0xFF.
- R2: The status byte uses bit 7 = ready for host, bit 6 = direction (1 = controller to host), bit 5 = non-DMA, bit 4 = busy, and bits 3..0 read as 0. It reads 0x80 when idle and 0x90 while parameters are collected. During execution bit 7 is 0, bit 4 is 1, and bit 6 is 1 for read and 0 for write and format. It reads 0xD0 (bit 5 clear) in the result phase.
- R3: Opcodes decode by mask. (op & 0x1F) = 0x06 is read, (op & 0x3F) = 0x05 is write, (op & 0xBF) = 0x0D is format. Seek is exactly 0x0F, recalibrate 0x07, sense interrupt 0x08, specify 0x03 and sense drive 0x04. Any other byte leaves the block idle (status 0x80).
- R4: Read and write take 8 parameter bytes: unit, cylinder, head, record, size, end-of-track, gap, data length. Format takes 5: unit, size, records per track, gap, filler. The cycle after the last byte, `xfer_start` pulses for one cycle. At that point `xfer_kind` is 1 for read, 2 for write and 3 for format, `xfer_unit` carries bits 2..0 of the unit byte, and cylinder/head/record/size are as loaded. Format loads records-per-track into the record field.
- R5: When `xfer_done` arrives, the block enters the result phase and returns 7 bytes in this order: ST0, ST1, ST2, cylinder, head, record, size. ST0 bits 7..6 hold `xfer_ic` and bits 1..0 hold the unit's drive bits. ST1 and ST2 are the engine's bytes. After the seventh read the block is idle.
- R6: Seek (2 parameters: unit, target) sets the present cylinder to the target. Recalibrate (1 parameter: unit) sets it to 0. Both set ST0 bit 5 and return to idle with no result phase. Sense interrupt enters the result phase right after its opcode and returns ST0, then the present cylinder.
- R7: Sense drive takes one unit byte and returns one byte, ST3. ST3 has bits 1..0 = drive bits of the unit byte, bit 2 = two-sided, bit 4 = track 0, bit 5 = ready, bit 6 = write protect, and the other bits 0. The drive bits are sampled when the unit byte is written.
- R8: Specify takes 2 parameter bytes and returns to idle with no result phase. Status bit 5 reads 1 only during execution, and only when bit 0 of the second specify byte was 1.
- R9: A write to address 2 sets the motor enables of drives 3..0 from data bits 7..4 and the drive select from bits 1..0.
- R10: A data port read while idle or collecting parameters returns 0xFF and changes nothing. A data port write in the result phase is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address (2 control, 4 status, 5 data) |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| motor_en | output | 4 | Motor enables, one per drive |
| drive_sel | output | 2 | Selected drive |
| drv_track0 | input | 1 | Head of the addressed drive is at track 0 |
| drv_ready | input | 1 | Addressed drive ready |
| drv_wprot | input | 1 | Addressed drive write protected |
| drv_two_side | input | 1 | Addressed drive is two-sided |
| xfer_start | output | 1 | One-cycle start to the transfer engine |
| xfer_kind | output | 2 | 1 read, 2 write, 3 format |
| xfer_unit | output | 3 | Head (bit 2) and drive (bits 1..0) |
| xfer_cyl | output | 8 | Cylinder field |
| xfer_head | output | 8 | Head field |
| xfer_rec | output | 8 | Record field (records per track for format) |
| xfer_size | output | 8 | Size code |
| xfer_done | input | 1 | Engine finished |
| xfer_ic | input | 2 | Interrupt code for ST0 bits 7..6 |
| xfer_st1 | input | 8 | ST1 from the engine |
| xfer_st2 | input | 8 | ST2 from the engine |

## Verification
The embedded properties cover the per-cycle invariants. They check the status-byte flags in the result and execution phases, that the non-DMA flag appears only during execution with non-DMA configured, and that the start pulse lasts one cycle and coincides with execution. They also check that data reads return 0xFF outside the result phase, that result-phase writes leave the phase and step alone, and that the final result read or an unknown opcode lands in idle. The scenarios are needed to show the byte ordering and contents. These include the mask-based decode with the high opcode bits set, the parameter counts, the values handed to the engine, the seven-byte result with the engine's codes merged into ST0, and the present cylinder after seek and recalibrate. They also include the ST3 packing and the motor bits.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    OP_NONE, OP_READ, OP_WRITE, OP_FORMAT, OP_SEEK,
    OP_RECAL, OP_SENSE_INT, OP_SPECIFY, OP_SENSE_DRV
  } fdc_op_e;

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_EXEC, PH_RES} fdc_phase_e;

  localparam logic [1:0] XK_NONE   = 2'd0;
  localparam logic [1:0] XK_READ   = 2'd1;
  localparam logic [1:0] XK_WRITE  = 2'd2;
  localparam logic [1:0] XK_FORMAT = 2'd3;

  // Mask-based opcode decode; the upper option bits are ignored where allowed.
  function automatic fdc_op_e decode_op(input logic [BYTE_W-1:0] b);
    fdc_op_e o;
    o = OP_NONE;
    if ((b & 8'h1F) == 8'h06) o = OP_READ;
    if ((b & 8'h3F) == 8'h05) o = OP_WRITE;
    if ((b & 8'hBF) == 8'h0D) o = OP_FORMAT;
    if (b == 8'h0F) o = OP_SEEK;
    if (b == 8'h07) o = OP_RECAL;
    if (b == 8'h08) o = OP_SENSE_INT;
    if (b == 8'h03) o = OP_SPECIFY;
    if (b == 8'h04) o = OP_SENSE_DRV;
    return o;
  endfunction

  function automatic logic [3:0] param_count(input fdc_op_e o);
    case (o)
      OP_READ, OP_WRITE:      return 4'd8;
      OP_FORMAT:              return 4'd5;
      OP_SEEK, OP_SPECIFY:    return 4'd2;
      OP_RECAL, OP_SENSE_DRV: return 4'd1;
      default:                return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] result_count(input fdc_op_e o);
    case (o)
      OP_READ, OP_WRITE, OP_FORMAT: return 4'd7;
      OP_SENSE_INT:                 return 4'd2;
      OP_SENSE_DRV:                 return 4'd1;
      default:                      return 4'd0;
    endcase
  endfunction

  function automatic logic [1:0] xfer_kind_of(input fdc_op_e o);
    case (o)
      OP_READ:   return XK_READ;
      OP_WRITE:  return XK_WRITE;
      OP_FORMAT: return XK_FORMAT;
      default:   return XK_NONE;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] pack_st3(input logic [1:0] ds, input logic two,
                                                 input logic trk0, input logic rdy,
                                                 input logic wp);
    return {1'b0, wp, rdy, trk0, 1'b0, two, ds};
  endfunction

  function automatic logic [BYTE_W-1:0] pack_msr(input fdc_phase_e ph, input logic to_host,
                                                 input logic ndm);
    case (ph)
      PH_IDLE: return 8'h80;
      PH_CMD:  return 8'h90;
      PH_EXEC: return {1'b0, to_host, ndm, 1'b1, 4'h0};
      PH_RES:  return 8'hD0;
      default: return 8'h80;
    endcase
  endfunction

endpackage

// File: rtl/fdc_opdecode.sv
module fdc_opdecode
  import fdc_seq_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output fdc_op_e           op
);
  assign op = decode_op(opcode);
endmodule

// File: rtl/fdc_msr.sv
module fdc_msr
  import fdc_seq_pkg::*;
(
  input  fdc_phase_e        phase,
  input  logic              to_host,
  input  logic              ndm_cfg,
  output logic [BYTE_W-1:0] msr
);
  logic ndm_active;
  assign ndm_active = ndm_cfg && (phase == PH_EXEC);
  assign msr = pack_msr(phase, to_host, ndm_active);
endmodule

// File: rtl/fdc_result_mux.sv
module fdc_result_mux
  import fdc_seq_pkg::*;
(
  input  fdc_op_e           op,
  input  logic [3:0]        step,
  input  logic [BYTE_W-1:0] st0,
  input  logic [BYTE_W-1:0] st1,
  input  logic [BYTE_W-1:0] st2,
  input  logic [BYTE_W-1:0] st3,
  input  logic [BYTE_W-1:0] cyl,
  input  logic [BYTE_W-1:0] head,
  input  logic [BYTE_W-1:0] rec,
  input  logic [BYTE_W-1:0] size,
  input  logic [BYTE_W-1:0] pcn,
  output logic [BYTE_W-1:0] res_byte
);
  always_comb begin
    res_byte = 8'hFF;
    case (op)
      OP_READ, OP_WRITE, OP_FORMAT:
        case (step)
          4'd0: res_byte = st0;
          4'd1: res_byte = st1;
          4'd2: res_byte = st2;
          4'd3: res_byte = cyl;
          4'd4: res_byte = head;
          4'd5: res_byte = rec;
          4'd6: res_byte = size;
          default: res_byte = 8'hFF;
        endcase
      OP_SENSE_INT: res_byte = (step == 4'd0) ? st0 : pcn;
      OP_SENSE_DRV: res_byte = st3;
      default: res_byte = 8'hFF;
    endcase
  end
endmodule

// File: rtl/fdc_ctrl_reg.sv
module fdc_ctrl_reg #(
  parameter int NUM_DRIVES = 4,
  localparam int DSEL_W = $clog2(NUM_DRIVES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [NUM_DRIVES-1:0] motor_d,
  input  logic [DSEL_W-1:0]     sel_d,
  output logic [NUM_DRIVES-1:0] motor_en,
  output logic [DSEL_W-1:0]     drive_sel
);
  for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_motor
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)  motor_en[i] <= 1'b0;
      else if (wr) motor_en[i] <= motor_d[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  drive_sel <= '0;
    else if (wr) drive_sel <= sel_d;

  // R9: a control write lands in the motor and select outputs next cycle
  p_motor_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (motor_en == $past(motor_d)) && (drive_sel == $past(sel_d)));
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_seq_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 3'd2,
  parameter logic [ADDR_W-1:0] ADDR_MSR  = 3'd4,
  parameter logic [ADDR_W-1:0] ADDR_DATA = 3'd5,
  localparam int DSEL_W = $clog2(NUM_DRIVES),
  localparam int MOTOR_LSB = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [BYTE_W-1:0]     bus_wdata,
  output logic [BYTE_W-1:0]     bus_rdata,
  output logic [NUM_DRIVES-1:0] motor_en,
  output logic [DSEL_W-1:0]     drive_sel,
  input  logic                  drv_track0,
  input  logic                  drv_ready,
  input  logic                  drv_wprot,
  input  logic                  drv_two_side,
  output logic                  xfer_start,
  output logic [1:0]            xfer_kind,
  output logic [2:0]            xfer_unit,
  output logic [BYTE_W-1:0]     xfer_cyl,
  output logic [BYTE_W-1:0]     xfer_head,
  output logic [BYTE_W-1:0]     xfer_rec,
  output logic [BYTE_W-1:0]     xfer_size,
  input  logic                  xfer_done,
  input  logic [1:0]            xfer_ic,
  input  logic [BYTE_W-1:0]     xfer_st1,
  input  logic [BYTE_W-1:0]     xfer_st2
);

  fdc_phase_e        phase;
  fdc_op_e           cur_op, new_op;
  logic [3:0]        step;
  logic [BYTE_W-1:0] st0, st1, st2, st3, pcn;
  logic              ndm_cfg;
  logic [BYTE_W-1:0] msr, res_byte;

  // Named events for assertions
  logic data_wr_evt, data_rd_evt, ctrl_wr_evt, last_param, last_result;
  assign data_wr_evt = bus_wr && (bus_addr == ADDR_DATA);
  assign data_rd_evt = bus_rd && (bus_addr == ADDR_DATA);
  assign ctrl_wr_evt = bus_wr && (bus_addr == ADDR_CTRL);
  assign last_param  = (step == param_count(cur_op) - 4'd1);
  assign last_result = (step == result_count(cur_op) - 4'd1);

  fdc_opdecode u_dec (.opcode(bus_wdata), .op(new_op));

  fdc_msr u_msr (
    .phase(phase), .to_host(cur_op == OP_READ), .ndm_cfg(ndm_cfg), .msr(msr)
  );

  fdc_result_mux u_res (
    .op(cur_op), .step(step), .st0(st0), .st1(st1), .st2(st2), .st3(st3),
    .cyl(xfer_cyl), .head(xfer_head), .rec(xfer_rec), .size(xfer_size),
    .pcn(pcn), .res_byte(res_byte)
  );

  fdc_ctrl_reg #(.NUM_DRIVES(NUM_DRIVES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr_evt),
    .motor_d(bus_wdata[MOTOR_LSB +: NUM_DRIVES]), .sel_d(bus_wdata[DSEL_W-1:0]),
    .motor_en(motor_en), .drive_sel(drive_sel)
  );

  assign xfer_kind = xfer_kind_of(cur_op);

  always_comb begin
    if (bus_addr == ADDR_MSR)                            bus_rdata = msr;
    else if (bus_addr == ADDR_DATA && phase == PH_RES)   bus_rdata = res_byte;
    else                                                 bus_rdata = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      cur_op     <= OP_NONE;
      step       <= '0;
      st0        <= '0;
      st1        <= '0;
      st2        <= '0;
      st3        <= '0;
      pcn        <= '0;
      ndm_cfg    <= 1'b0;
      xfer_start <= 1'b0;
      xfer_unit  <= '0;
      xfer_cyl   <= '0;
      xfer_head  <= '0;
      xfer_rec   <= '0;
      xfer_size  <= '0;
    end else begin
      xfer_start <= 1'b0;
      unique case (phase)
        PH_IDLE: if (data_wr_evt) begin
          cur_op <= new_op;
          step   <= '0;
          case (new_op)
            OP_READ, OP_WRITE, OP_FORMAT: begin
              st0[7:6] <= 2'b00;
              st1      <= '0;
              st2      <= '0;
              phase    <= PH_CMD;
            end
            OP_RECAL: begin
              st0[5] <= 1'b0;
              phase  <= PH_CMD;
            end
            OP_SENSE_INT:                      phase <= PH_RES;
            OP_SEEK, OP_SPECIFY, OP_SENSE_DRV: phase <= PH_CMD;
            default:                           phase <= PH_IDLE;
          endcase
        end
        PH_CMD: if (data_wr_evt) begin
          step <= step + 4'd1;
          if (step == 4'd0 && cur_op != OP_SPECIFY) begin
            st0[1:0]  <= bus_wdata[1:0];
            st0[7:6]  <= 2'b00;
            xfer_unit <= bus_wdata[2:0];
            st3 <= pack_st3(bus_wdata[1:0], drv_two_side, drv_track0, drv_ready, drv_wprot);
          end
          case (cur_op)
            OP_READ, OP_WRITE:
              case (step)
                4'd1: xfer_cyl  <= bus_wdata;
                4'd2: xfer_head <= bus_wdata;
                4'd3: xfer_rec  <= bus_wdata;
                4'd4: xfer_size <= bus_wdata;
                default: ;
              endcase
            OP_FORMAT:
              case (step)
                4'd1: xfer_size <= bus_wdata;
                4'd2: xfer_rec  <= bus_wdata;
                default: ;
              endcase
            default: ;
          endcase
          if (last_param) begin
            step <= '0;
            case (cur_op)
              OP_READ, OP_WRITE, OP_FORMAT: begin
                phase      <= PH_EXEC;
                xfer_start <= 1'b1;
              end
              OP_SEEK: begin
                pcn    <= bus_wdata;
                st0[5] <= 1'b1;
                phase  <= PH_IDLE;
              end
              OP_RECAL: begin
                pcn    <= '0;
                st0[5] <= 1'b1;
                phase  <= PH_IDLE;
              end
              OP_SPECIFY: begin
                ndm_cfg <= bus_wdata[0];
                phase   <= PH_IDLE;
              end
              OP_SENSE_DRV: phase <= PH_RES;
              default:      phase <= PH_IDLE;
            endcase
          end
        end
        PH_EXEC: if (xfer_done) begin
          st0[7:6] <= xfer_ic;
          st1      <= xfer_st1;
          st2      <= xfer_st2;
          step     <= '0;
          phase    <= PH_RES;
        end
        PH_RES: if (data_rd_evt) begin
          if (last_result) begin
            phase <= PH_IDLE;
            step  <= '0;
          end else begin
            step <= step + 4'd1;
          end
        end
      endcase
    end
  end

  // R2: result phase shows ready, direction to host and busy
  p_res_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RES) |-> (msr[7:6] == 2'b11) && msr[4]);
  // R2: execution withholds ready but keeps busy
  p_exec_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC) |-> !msr[7] && msr[4]);
  // R8: non-DMA flag only during execution with non-DMA configured
  p_ndm_scope_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msr[5] |-> (phase == PH_EXEC) && ndm_cfg);
  // R4: start is a single-cycle pulse coinciding with execution
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (phase == PH_EXEC) ##1 !xfer_start);
  // R10: no data before the result phase
  p_idle_ff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == ADDR_DATA) && (phase inside {PH_IDLE, PH_CMD})) |-> (bus_rdata == 8'hFF));
  // R10: writes during the result phase change nothing
  p_res_wr_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_RES) && data_wr_evt && !data_rd_evt) |=> (phase == PH_RES) && $stable(step));
  // R5: final result byte returns to idle with busy clear
  p_last_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_RES) && data_rd_evt && last_result) |=> (phase == PH_IDLE) && !msr[4]);
  // R3: an unknown opcode keeps the block idle
  p_unknown_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_IDLE) && data_wr_evt && (new_op == OP_NONE)) |=> (phase == PH_IDLE));

endmodule

// File: tb/fdc_cmd_seq_test.sv
`timescale 1ns/100ps
module fdc_cmd_seq_test;
  localparam logic [2:0] A_CTRL = 3'd2, A_MSR = 3'd4, A_DATA = 3'd5;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic [3:0] motor_en;
  logic [1:0] drive_sel;
  logic       drv_track0 = 1'b0, drv_ready = 1'b0, drv_wprot = 1'b0, drv_two_side = 1'b0;
  logic       xfer_start, xfer_done = 1'b0;
  logic [1:0] xfer_kind, xfer_ic = 2'b00;
  logic [2:0] xfer_unit;
  logic [7:0] xfer_cyl, xfer_head, xfer_rec, xfer_size;
  logic [7:0] xfer_st1 = 8'h00, xfer_st2 = 8'h00;

  int n_cmp = 0, n_bad = 0, n_start = 0;
  bit finished = 1'b0;
  logic [1:0] cap_kind;
  logic [2:0] cap_unit;
  logic [7:0] cap_c, cap_h, cap_r, cap_n;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  fdc_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .motor_en(motor_en), .drive_sel(drive_sel),
    .drv_track0(drv_track0), .drv_ready(drv_ready), .drv_wprot(drv_wprot),
    .drv_two_side(drv_two_side), .xfer_start(xfer_start), .xfer_kind(xfer_kind),
    .xfer_unit(xfer_unit), .xfer_cyl(xfer_cyl), .xfer_head(xfer_head), .xfer_rec(xfer_rec),
    .xfer_size(xfer_size), .xfer_done(xfer_done), .xfer_ic(xfer_ic),
    .xfer_st1(xfer_st1), .xfer_st2(xfer_st2)
  );

  // Engine-side monitor: capture what is handed over on each start pulse
  always @(negedge clk) if (xfer_start) begin
    n_start++;
    cap_kind = xfer_kind; cap_unit = xfer_unit;
    cap_c = xfer_cyl; cap_h = xfer_head; cap_r = xfer_rec; cap_n = xfer_size;
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_port(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_port(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic msr_is(input logic [7:0] e, input string tag);
    logic [7:0] v;
    rd_port(A_MSR, v);
    chk(v, e, tag);
  endtask

  // Scoreboard driver side: queue expected result bytes
  task automatic expect_byte(input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  // Scoreboard monitor side: read result bytes and compare in order
  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      rd_port(A_DATA, v);
      chk(v, exp_q.pop_front(), tag_q.pop_front());
    end
  endtask

  task automatic serve_xfer(input logic [1:0] kind, input logic [2:0] unit,
                            input logic [7:0] c, input logic [7:0] h,
                            input logic [7:0] r, input logic [7:0] n,
                            input int starts_before, input logic [7:0] msr_exec,
                            input logic [1:0] ic, input logic [7:0] s1, input logic [7:0] s2);
    @(negedge clk);
    chk(8'(n_start - starts_before), 8'd1, "R4 one start pulse");
    chk({6'd0, cap_kind}, {6'd0, kind}, "R4 kind");
    chk({5'd0, cap_unit}, {5'd0, unit}, "R4 unit");
    chk(cap_c, c, "R4 cyl");
    chk(cap_h, h, "R4 head");
    chk(cap_r, r, "R4 rec");
    chk(cap_n, n, "R4 size");
    msr_is(msr_exec, "R2 R8 exec status");
    @(negedge clk); xfer_done = 1'b1; xfer_ic = ic; xfer_st1 = s1; xfer_st2 = s2;
    @(negedge clk); xfer_done = 1'b0;
    msr_is(8'hD0, "R2 result status");
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int s0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    msr_is(8'h80, "R1 status after reset");
    chk({4'd0, motor_en}, 8'h00, "R1 motors");
    chk({6'd0, drive_sel}, 8'h00, "R1 drive select");
    rd_port(A_DATA, v); chk(v, 8'hFF, "R1 R10 idle data read");

    // R9 control register
    wr_port(A_CTRL, 8'hA3);
    chk({4'd0, motor_en}, 8'h0A, "R9 motors A3");
    chk({6'd0, drive_sel}, 8'h03, "R9 select A3");
    wr_port(A_CTRL, 8'h51);
    chk({4'd0, motor_en}, 8'h05, "R9 motors 51");
    chk({6'd0, drive_sel}, 8'h01, "R9 select 51");

    // Write with MFM bit set: 0x45 (R3), no non-DMA yet (R8)
    wr_port(A_DATA, 8'h45);
    msr_is(8'h90, "R2 R3 command phase");
    s0 = n_start;
    foreach (v8_write[i]) wr_port(A_DATA, v8_write[i]);
    serve_xfer(2'd2, 3'd2, 8'h20, 8'h00, 8'h01, 8'h03, s0, 8'h10, 2'b00, 8'h02, 8'h00);
    expect_byte(8'h02, "R5 write ST0"); expect_byte(8'h02, "R5 write ST1");
    expect_byte(8'h00, "R5 write ST2"); expect_byte(8'h20, "R5 write C");
    expect_byte(8'h00, "R5 write H");   expect_byte(8'h01, "R5 write R");
    expect_byte(8'h03, "R5 write N");
    drain(7);
    msr_is(8'h80, "R5 idle after write results");

    // R8 specify with non-DMA bit
    wr_port(A_DATA, 8'h03);
    wr_port(A_DATA, 8'h5A);
    msr_is(8'h90, "R8 specify midway");
    wr_port(A_DATA, 8'h01);
    msr_is(8'h80, "R8 specify no result");

    // Read with MT/MFM/SK set: 0xE6 (R3)
    wr_port(A_DATA, 8'hE6);
    s0 = n_start;
    foreach (v8_read[i]) wr_port(A_DATA, v8_read[i]);
    serve_xfer(2'd1, 3'd5, 8'h12, 8'h01, 8'h03, 8'h02, s0, 8'h70, 2'b01, 8'h10, 8'h00);
    expect_byte(8'h41, "R5 read ST0"); expect_byte(8'h10, "R5 read ST1");
    expect_byte(8'h00, "R5 read ST2"); expect_byte(8'h12, "R5 read C");
    expect_byte(8'h01, "R5 read H");   expect_byte(8'h03, "R5 read R");
    expect_byte(8'h02, "R5 read N");
    drain(2);
    wr_port(A_DATA, 8'h08);
    msr_is(8'hD0, "R10 result write ignored");
    drain(5);
    msr_is(8'h80, "R5 idle after read results");

    // Format 0x4D (R3): C/H carried from the read
    wr_port(A_DATA, 8'h4D);
    s0 = n_start;
    foreach (v8_fmt[i]) wr_port(A_DATA, v8_fmt[i]);
    serve_xfer(2'd3, 3'd0, 8'h12, 8'h01, 8'h09, 8'h02, s0, 8'h30, 2'b00, 8'h00, 8'h01);
    expect_byte(8'h00, "R5 fmt ST0"); expect_byte(8'h00, "R5 fmt ST1");
    expect_byte(8'h01, "R5 fmt ST2"); expect_byte(8'h12, "R5 fmt C");
    expect_byte(8'h01, "R5 fmt H");   expect_byte(8'h09, "R5 fmt R");
    expect_byte(8'h02, "R5 fmt N");
    drain(7);

    // R6 seek, with a stray data read in command phase (R10)
    wr_port(A_DATA, 8'h0F);
    wr_port(A_DATA, 8'h01);
    rd_port(A_DATA, v); chk(v, 8'hFF, "R10 command phase read");
    msr_is(8'h90, "R10 command phase unchanged");
    wr_port(A_DATA, 8'h28);
    msr_is(8'h80, "R6 seek no result");
    wr_port(A_DATA, 8'h08);
    msr_is(8'hD0, "R6 sense int straight to result");
    expect_byte(8'h21, "R6 sense ST0 after seek");
    expect_byte(8'h28, "R6 cylinder after seek");
    drain(2);
    msr_is(8'h80, "R6 idle after sense");

    // R6 recalibrate
    wr_port(A_DATA, 8'h07);
    wr_port(A_DATA, 8'h03);
    msr_is(8'h80, "R6 recal no result");
    wr_port(A_DATA, 8'h08);
    expect_byte(8'h23, "R6 sense ST0 after recal");
    expect_byte(8'h00, "R6 cylinder after recal");
    drain(2);

    // R7 sense drive
    drv_track0 = 1'b1; drv_ready = 1'b1; drv_wprot = 1'b0; drv_two_side = 1'b1;
    wr_port(A_DATA, 8'h04);
    wr_port(A_DATA, 8'h06);
    msr_is(8'hD0, "R7 result after one parameter");
    expect_byte(8'h36, "R7 ST3 a"); drain(1);
    msr_is(8'h80, "R7 idle after ST3");
    drv_track0 = 1'b0; drv_ready = 1'b0; drv_wprot = 1'b1; drv_two_side = 1'b0;
    wr_port(A_DATA, 8'h04);
    wr_port(A_DATA, 8'h01);
    expect_byte(8'h41, "R7 ST3 b"); drain(1);

    // R3 unknown opcodes stay idle and change nothing
    wr_port(A_DATA, 8'h1F); msr_is(8'h80, "R3 unknown 1F");
    wr_port(A_DATA, 8'h8F); msr_is(8'h80, "R3 unknown 8F");
    wr_port(A_DATA, 8'h25); msr_is(8'h80, "R3 unknown 25");
    rd_port(A_DATA, v); chk(v, 8'hFF, "R10 idle read after unknown");
    wr_port(A_DATA, 8'h08);
    expect_byte(8'h21, "R3 ST0 kept"); expect_byte(8'h00, "R3 cylinder kept");
    drain(2);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [7:0] v8_write [8] = '{8'h02, 8'h20, 8'h00, 8'h01, 8'h03, 8'h09, 8'h1B, 8'hFF};
  logic [7:0] v8_read  [8] = '{8'h05, 8'h12, 8'h01, 8'h03, 8'h02, 8'h09, 8'h2A, 8'hFF};
  logic [7:0] v8_fmt   [5] = '{8'h00, 8'h02, 8'h09, 8'h50, 8'hE5};

endmodule